// File: doc/BRIEF.md
# Windowed Register File with Hardwired Zero Register

This block holds a processor's general registers. An instruction names one of 64 logical registers through a 6-bit index. A movable window base maps that index onto a row of a larger backing store. The base is stepped up or down by one position at a time, so a routine can open a fresh set of registers without copying any. Consecutive windows overlap, which lets a caller pass pointer bytes to the callee. Logical register 0 always reads as zero and cannot be written in any window. A multi-byte address can therefore be built from ordinary registers with a guaranteed zero available.

The window base is a chain of 4-bit stages. Each stage passes a carry (counting up) or a borrow (counting down) to the stage above it. When the whole chain wraps in either direction, a registered one-cycle pulse reports it. Because the pulse comes from a flop and not from the ripple between stages, the outputs of slow stages can never cause a glitch on it.

Writes enter on a port that accepts every cycle. Reads use a request/response stream. A request is taken when `rq_valid` and `rq_ready` are both high. Its data appears one cycle later with `rs_valid` high. That response is held, unchanged, until `rs_ready` is high. While a response is held back, `rq_ready` is low and new requests wait. After the index-plus-base addition, the output is chosen by a multiplexer, so `rs_data` always carries a defined value.

Top module: `wrf_top`

## Requirements
- R1: After reset, `win_base` is 0x00, `win_wrap` is 0, `rs_valid` is 0, and `rq_ready` and `wr_ready` are 1.
- R2: `wr_ready` is always 1. A write with `wr_valid`=1 stores `wr_data` at the row of `wr_idx` under the current window, and a later read of the same row returns that value.
- R3: Logical index 0 reads 0x00 in every window. A write to index 0 is ignored, including a write in the same cycle as a read of index 0.
- R4: A request accepted on edge N gives `rs_valid`=1 with its data after edge N. The data is the row content before any write made on that same edge.
- R5: While `rs_valid`=1 and `rs_ready`=0, `rs_data` and `rs_valid` hold and `rq_ready` is 0, so no new request is accepted. With `rs_ready`=1 and no new request, `rs_valid` falls on the next edge.
- R6: `win_up` alone adds 1 to `win_base` and `win_dn` alone subtracts 1, with carry and borrow passed between 4-bit stages (0x0F up gives 0x10, and 0x10 down gives 0x0F). Both high or both low leaves the base unchanged.
- R7: Stepping up from 0xFF gives 0x00 and stepping down from 0x00 gives 0xFF. `win_wrap` is 1 for exactly the one cycle after that edge and 0 in every other cycle.
- R8: Logical index i under base b selects row (4*b + i) mod 1024. So index i under base b+1 is the same row as index i+4 under base b, and index 63 under base 0xFF is the same row as index 59 under base 0x00.
- R9: A read or write in the same cycle as a window step uses the base from before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_idx | input | 6 | Logical register index to write |
| wr_data | input | 8 | Write data |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request can be taken |
| rq_idx | input | 6 | Logical register index to read |
| rs_valid | output | 1 | Read response valid |
| rs_ready | input | 1 | Consumer takes the response |
| rs_data | output | 8 | Read response data |
| win_up | input | 1 | Step window base up |
| win_dn | input | 1 | Step window base down |
| win_base | output | 8 | Current window base |
| win_wrap | output | 1 | One-cycle pulse after the base wraps |

## Verification
The bench tries to write register 0, both alone and in the same cycle as a read of it. A design that lost the zero protection would return the written byte. It steps the base across a stage boundary in both directions and across the full range at each end. A broken carry or borrow chain would show a wrong base, and a combinational or stretched wrap flag would show `win_wrap` in the wrong cycle. It also issues reads that collide with a write or a window step on the same edge. It holds a response back while new requests wait; a design that ignored back-pressure would overwrite the pending data. Finally, it reads across overlapping windows and across the wrap of the backing store, where a wrong row mapping returns a stale byte.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int DATA_W_D  = 8;
  localparam int IDX_W_D   = 6;
  localparam int DIGIT_W_D = 4;
  localparam int DIGITS_D  = 2;
  localparam int STEP_SH_D = 2;
  localparam int ROW_W_D   = 10;

  typedef enum logic [1:0] {
    WIN_HOLD = 2'd0,
    WIN_INC  = 2'd1,
    WIN_DEC  = 2'd2
  } win_op_e;
endpackage

// File: rtl/wrf_win_digit.sv
module wrf_win_digit
  import wrf_pkg::*;
#(
  parameter int W = DIGIT_W_D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  win_op_e       op,
  input  logic          chain_in,
  output logic          chain_out,
  output logic [W-1:0]  digit
);
  localparam logic [W-1:0] ALL_ONES = '1;

  always_comb begin
    chain_out = 1'b0;
    if (chain_in) begin
      if (op == WIN_INC) chain_out = (digit == ALL_ONES);
      else if (op == WIN_DEC) chain_out = (digit == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digit <= '0;
    end else if (chain_in) begin
      if (op == WIN_INC)      digit <= digit + 1'b1;
      else if (op == WIN_DEC) digit <= digit - 1'b1;
    end
  end
endmodule

// File: rtl/wrf_win_ctr.sv
module wrf_win_ctr
  import wrf_pkg::*;
#(
  parameter int DIGIT_W = DIGIT_W_D,
  parameter int DIGITS  = DIGITS_D,
  localparam int WIN_W  = DIGIT_W * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [WIN_W-1:0] base,
  output logic             wrap
);
  win_op_e           op;
  logic [DIGITS:0]   chain;

  always_comb begin
    if (step_up && !step_dn)      op = WIN_INC;
    else if (step_dn && !step_up) op = WIN_DEC;
    else                          op = WIN_HOLD;
  end

  assign chain[0] = (op != WIN_HOLD);

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    wrf_win_digit #(.W(DIGIT_W)) digit_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .chain_in  (chain[g]),
      .chain_out (chain[g+1]),
      .digit     (base[g*DIGIT_W +: DIGIT_W])
    );
  end

  // The ripple out of the top stage is only looked at on the edge.
  always_ff @(posedge clk) begin
    if (!rst_n) wrap <= 1'b0;
    else        wrap <= chain[DIGITS];
  end
endmodule

// File: rtl/wrf_row_map.sv
module wrf_row_map #(
  parameter int IDX_W   = 6,
  parameter int WIN_W   = 8,
  parameter int STEP_SH = 2,
  parameter int ROW_W   = 10
) (
  input  logic [WIN_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  output logic [ROW_W-1:0] row,
  output logic             is_zero
);
  assign row     = (ROW_W'(base) << STEP_SH) + ROW_W'(idx);
  assign is_zero = (idx == '0);
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 10,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ROW_W-1:0]  rrow,
  input  logic              rzero,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic              zero_q;

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= wdata;
    if (re) mem_q <= mem[rrow];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  zero_q <= 1'b1;
    else if (re) zero_q <= rzero;
  end

  // Output select after the address addition: zero or stored byte.
  always_comb begin
    if (zero_q) rdata = '0;
    else        rdata = mem_q;
  end
endmodule

// File: rtl/wrf_top.sv
module wrf_top
  import wrf_pkg::*;
#(
  parameter int DATA_W  = DATA_W_D,
  parameter int IDX_W   = IDX_W_D,
  parameter int DIGIT_W = DIGIT_W_D,
  parameter int DIGITS  = DIGITS_D,
  parameter int STEP_SH = STEP_SH_D,
  parameter int ROW_W   = ROW_W_D,
  localparam int WIN_W  = DIGIT_W * DIGITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [IDX_W-1:0]  rq_idx,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [DATA_W-1:0] rs_data,
  input  logic              win_up,
  input  logic              win_dn,
  output logic [WIN_W-1:0]  win_base,
  output logic              win_wrap
);
  logic [ROW_W-1:0] w_row, r_row;
  logic             w_zero, r_zero;
  logic             rd_fire;

  wrf_win_ctr #(.DIGIT_W(DIGIT_W), .DIGITS(DIGITS)) ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_up (win_up),
    .step_dn (win_dn),
    .base    (win_base),
    .wrap    (win_wrap)
  );

  wrf_row_map #(.IDX_W(IDX_W), .WIN_W(WIN_W), .STEP_SH(STEP_SH), .ROW_W(ROW_W)) wmap_i (
    .base    (win_base),
    .idx     (wr_idx),
    .row     (w_row),
    .is_zero (w_zero)
  );

  wrf_row_map #(.IDX_W(IDX_W), .WIN_W(WIN_W), .STEP_SH(STEP_SH), .ROW_W(ROW_W)) rmap_i (
    .base    (win_base),
    .idx     (rq_idx),
    .row     (r_row),
    .is_zero (r_zero)
  );

  assign wr_ready = 1'b1;
  assign rq_ready = !rs_valid || rs_ready;
  assign rd_fire  = rq_valid && rq_ready;

  wrf_store #(.DATA_W(DATA_W), .ROW_W(ROW_W)) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_valid && !w_zero),
    .wrow  (w_row),
    .wdata (wr_data),
    .re    (rd_fire),
    .rrow  (r_row),
    .rzero (r_zero),
    .rdata (rs_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        rs_valid <= 1'b0;
    else if (rd_fire)  rs_valid <= 1'b1;
    else if (rs_ready) rs_valid <= 1'b0;
  end
endmodule

// File: rtl/wrf_top_chk.sv
module wrf_top_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6,
  parameter int WIN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rq_valid,
  input logic              rq_ready,
  input logic [IDX_W-1:0]  rq_idx,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic [DATA_W-1:0] rs_data,
  input logic              win_up,
  input logic              win_dn,
  input logic [WIN_W-1:0]  win_base,
  input logic              win_wrap
);
  localparam logic [WIN_W-1:0] TOP = '1;

  // R3
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready && rq_idx == '0) |=> (rs_valid && rs_data == '0));

  // R5
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data)));

  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_up && !win_dn) |=> (win_base == WIN_W'($past(win_base) + 1'b1)));

  // R6
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_dn && !win_up) |=> (win_base == WIN_W'($past(win_base) - 1'b1)));

  // R6
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_up == win_dn) |=> ($stable(win_base) && !win_wrap));

  // R7
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_up && !win_dn && win_base == TOP) |=> (win_wrap && win_base == '0));

  // R7
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wrap |=> !win_wrap);
endmodule

bind wrf_top wrf_top_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WIN_W(WIN_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rq_valid (rq_valid),
  .rq_ready (rq_ready),
  .rq_idx   (rq_idx),
  .rs_valid (rs_valid),
  .rs_ready (rs_ready),
  .rs_data  (rs_data),
  .win_up   (win_up),
  .win_dn   (win_dn),
  .win_base (win_base),
  .win_wrap (win_wrap)
);

// File: tb/wrf_top_tb_top.sv
module wrf_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [5:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       rq_valid = 1'b0;
  logic       rq_ready;
  logic [5:0] rq_idx = '0;
  logic       rs_valid;
  logic       rs_ready = 1'b1;
  logic [7:0] rs_data;
  logic       win_up = 1'b0;
  logic       win_dn = 1'b0;
  logic [7:0] win_base;
  logic       win_wrap;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  wrf_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_idx(rq_idx),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data),
    .win_up(win_up), .win_dn(win_dn), .win_base(win_base), .win_wrap(win_wrap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [5:0] idx, input logic [7:0] d);
    wr_valid = 1'b1; wr_idx = idx; wr_data = d;
    cyc();
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [5:0] idx, input logic [7:0] exp);
    rq_valid = 1'b1; rq_idx = idx;
    cyc();
    rq_valid = 1'b0;
    chk({req, " rs_valid"}, rs_valid, 1);
    chk({req, " rs_data"}, rs_data, exp);
  endtask

  task automatic step(input logic up, input logic dn);
    win_up = up; win_dn = dn;
    cyc();
    win_up = 1'b0; win_dn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 base", win_base, 8'h00);
    chk("R1 wrap", win_wrap, 0);
    chk("R1 rs_valid", rs_valid, 0);
    chk("R1 rq_ready", rq_ready, 1);
    chk("R1 wr_ready", wr_ready, 1);
  endtask

  task automatic t_write_read();
    do_write(6'd5, 8'hA5);
    do_write(6'd63, 8'h3C);
    chk("R2 wr_ready", wr_ready, 1);
    do_read("R2 idx5", 6'd5, 8'hA5);
    do_read("R2 idx63", 6'd63, 8'h3C);
  endtask

  task automatic t_zero();
    do_write(6'd0, 8'hFF);
    do_read("R3 idx0 after write", 6'd0, 8'h00);
    wr_valid = 1'b1; wr_idx = 6'd0; wr_data = 8'h5A;
    rq_valid = 1'b1; rq_idx = 6'd0;
    cyc();
    wr_valid = 1'b0; rq_valid = 1'b0;
    chk("R3 same-cycle zero", rs_data, 8'h00);
    do_read("R3 idx0 again", 6'd0, 8'h00);
  endtask

  task automatic t_same_cycle();
    do_write(6'd7, 8'h11);
    wr_valid = 1'b1; wr_idx = 6'd7; wr_data = 8'h22;
    rq_valid = 1'b1; rq_idx = 6'd7;
    cyc();
    wr_valid = 1'b0; rq_valid = 1'b0;
    chk("R4 read-before-write valid", rs_valid, 1);
    chk("R4 read-before-write data", rs_data, 8'h11);
    do_read("R4 new value", 6'd7, 8'h22);
  endtask

  task automatic t_window();
    step(1'b1, 1'b0);
    chk("R6 base after up", win_base, 8'h01);
    do_read("R8 overlap idx1@1 = idx5@0", 6'd1, 8'hA5);
    do_write(6'd2, 8'h77);
    do_read("R3 idx0 in window 1", 6'd0, 8'h00);
    step(1'b0, 1'b1);
    chk("R6 base after down", win_base, 8'h00);
    do_read("R8 idx6@0 = idx2@1", 6'd6, 8'h77);
  endtask

  task automatic t_step_read();
    do_write(6'd3, 8'h33);
    rq_valid = 1'b1; rq_idx = 6'd3; win_up = 1'b1;
    cyc();
    rq_valid = 1'b0; win_up = 1'b0;
    chk("R9 read uses old base", rs_data, 8'h33);
    chk("R9 base moved", win_base, 8'h01);
    do_read("R8 idx3@1 = row7", 6'd3, 8'h22);
    wr_valid = 1'b1; wr_idx = 6'd4; wr_data = 8'h4B; win_dn = 1'b1;
    cyc();
    wr_valid = 1'b0; win_dn = 1'b0;
    do_read("R9 write used old base (row8)", 6'd8, 8'h4B);
  endtask

  task automatic t_both();
    step(1'b1, 1'b1);
    chk("R6 both held base", win_base, 8'h00);
    chk("R6 both no wrap", win_wrap, 0);
  endtask

  task automatic t_carry();
    bit saw_wrap = 1'b0;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0);
      if (win_wrap) saw_wrap = 1'b1;
    end
    chk("R6 carry 0F->10", win_base, 8'h10);
    chk("R7 no wrap on carry", saw_wrap, 0);
    step(1'b0, 1'b1);
    chk("R6 borrow 10->0F", win_base, 8'h0F);
    chk("R7 no wrap on borrow", win_wrap, 0);
  endtask

  task automatic t_wrap();
    bit saw_wrap = 1'b0;
    for (int i = 0; i < 240; i++) begin
      step(1'b1, 1'b0);
      if (win_wrap) saw_wrap = 1'b1;
    end
    chk("R6 reach FF", win_base, 8'hFF);
    chk("R7 no early wrap", saw_wrap, 0);
    do_write(6'd63, 8'h5E);
    step(1'b1, 1'b0);
    chk("R7 up wrap base", win_base, 8'h00);
    chk("R7 up wrap pulse", win_wrap, 1);
    cyc();
    chk("R7 up wrap one cycle", win_wrap, 0);
    do_read("R8 row wrap idx59@0", 6'd59, 8'h5E);
    step(1'b0, 1'b1);
    chk("R7 down wrap base", win_base, 8'hFF);
    chk("R7 down wrap pulse", win_wrap, 1);
    cyc();
    chk("R7 down wrap one cycle", win_wrap, 0);
    step(1'b1, 1'b0);
    chk("R7 back to 00", win_base, 8'h00);
  endtask

  task automatic t_backpressure();
    rs_ready = 1'b0;
    rq_valid = 1'b1; rq_idx = 6'd5;
    cyc();
    rq_idx = 6'd63;
    chk("R5 response valid", rs_valid, 1);
    chk("R5 response data", rs_data, 8'hA5);
    chk("R5 rq_ready low", rq_ready, 0);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R5 held valid", rs_valid, 1);
      chk("R5 held data", rs_data, 8'hA5);
    end
    rq_valid = 1'b0; rs_ready = 1'b1;
    cyc();
    chk("R5 drained", rs_valid, 0);
    chk("R5 ready again", rq_ready, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_write_read();
    t_zero();
    t_same_cycle();
    t_window();
    t_step_read();
    t_both();
    t_carry();
    t_wrap();
    t_backpressure();
    finish_run();
  end
endmodule